// File: doc/BRIEF.md
# Clocked Sequential Buffer Port with Two End Markers

This block is the synchronous, address-counting side of a 16-bit buffer memory. An internal address pointer steps through a word array on rising edges of the port clock, so a producer or consumer can stream words in or out without presenting an address. Each cycle, the port select, an active-low count enable, a read/write select and an active-low output enable decide whether the pointer moves and whether a word is read or stored. The random-access side of the memory is not part of this block.

Two comparators watch the pointer. Each drives its own active-low end marker. A marker drops when the pointer steps onto the matching end address and stays low until a reset or a start strobe. The start address and both end addresses come in on plain input ports. A reset or a start strobe reloads the pointer from the start address. The pointer width is a parameter. The default is 11 bits (2048 words), and 13 bits gives the full 8192-word array.

Top module: `seqport_buffer`

## Requirements
- R1: While `rst` is high at a rising edge, the pointer loads `start_ptr_i`. Both end markers go to 1 and `data_oe_o` goes to 0 after that edge.
- R2: When `start_i` is high at a rising edge and `rst` is low, the pointer loads `start_ptr_i` and both markers go to 1. No read or write takes place, and `data_oe_o` is 0 after that edge.
- R3: When `cnt_en_n_i` is 0 at an edge (and neither `rst` nor `start_i` is high), the pointer steps by one first. Any read or write in that cycle uses the stepped address.
- R4: When `cnt_en_n_i` is 1, a selected read or write uses the current pointer and the pointer does not change.
- R5: After a selected read (`sel_i`=1, `wr_n_i`=1), `data_o` carries the addressed word and `data_oe_o` is 1 only while `oe_n_i` is 0. In every other case `data_o` is all zeros and `data_oe_o` is 0.
- R6: With `sel_i`=0, nothing is read or written and `data_oe_o` is 0 after the edge. The pointer still steps if `cnt_en_n_i` is 0.
- R7: `eob1_n_o` drops to 0 on a stepping edge whose new pointer equals `end1_i`. `eob2_n_o` does the same for `end2_i`. The two markers are independent, and both can drop on the same edge.
- R8: On any edge where a marker's end address is not reached by a step, that marker keeps its value. This includes a non-stepping cycle that sits on the end address.
- R9: A selected cycle with `wr_n_i`=0 stores `data_i`, as sampled at that edge, at the address in use for that cycle.
- R10: A step from the all-ones address wraps the pointer to address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock; all actions on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start strobe: reload pointer, raise markers |
| start_ptr_i | input | ADDR_W | Start address for reset and start strobe |
| end1_i | input | ADDR_W | End address watched by marker 1 |
| end2_i | input | ADDR_W | End address watched by marker 2 |
| sel_i | input | 1 | Port select, 1 = selected |
| cnt_en_n_i | input | 1 | Count enable, 0 = step pointer |
| wr_n_i | input | 1 | 1 = read, 0 = write |
| oe_n_i | input | 1 | Output enable, 0 = drive read data |
| data_i | input | DATA_W | Write data |
| data_o | output | DATA_W | Read data, zero when not driven |
| data_oe_o | output | 1 | Bus drive enable for the data pad |
| eob1_n_o | output | 1 | End marker 1, active low |
| eob2_n_o | output | 1 | End marker 2, active low |

## Verification
The assertions check the following on every cycle: how the pointer moves under reset, the start strobe, stepping, holding and the wrap; that markers fall only on stepping edges and hold otherwise; and that the drive enable follows the output enable and the select. The data values themselves, meaning which word a read returns after a step, a hold or a deselected advance, and that a write lands where a later read finds it, can only be shown by the bench. The bench fills the whole array through the port and then replays reads, writes and pointer operations against its own model.

// File: rtl/seqport_pkg.sv
`timescale 1ns/1ps
package seqport_pkg;
  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_e;
endpackage

// File: rtl/seqport_counter.sv
`timescale 1ns/1ps
module seqport_counter #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              adv,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [ADDR_W-1:0] eff_addr
);
  // Step happens before the access; natural overflow gives the wrap.
  assign eff_addr = adv ? cur_addr + 1'b1 : cur_addr;

  always_ff @(posedge clk) begin
    if (rst || load) cur_addr <= load_val;
    else             cur_addr <= eff_addr;
  end
endmodule

// File: rtl/seqport_eob_flag.sv
`timescale 1ns/1ps
module seqport_eob_flag #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              adv,
  input  logic [ADDR_W-1:0] eff_addr,
  input  logic [ADDR_W-1:0] end_addr,
  output logic              flag_n
);
  always_ff @(posedge clk) begin
    if (rst || clr)                         flag_n <= 1'b1;
    else if (adv && (eff_addr == end_addr)) flag_n <= 1'b0;
  end
endmodule

// File: rtl/seqport_array.sv
`timescale 1ns/1ps
module seqport_array #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Single-port, registered read: maps onto block RAM.
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end
endmodule

// File: rtl/seqport_buffer.sv
`timescale 1ns/1ps
module seqport_buffer
  import seqport_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_ptr_i,
  input  logic [ADDR_W-1:0] end1_i,
  input  logic [ADDR_W-1:0] end2_i,
  input  logic              sel_i,
  input  logic              cnt_en_n_i,
  input  logic              wr_n_i,
  input  logic              oe_n_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              eob1_n_o,
  output logic              eob2_n_o
);
  localparam int NUM_EOB = 2;

  logic              active;
  logic              adv;
  acc_e              acc;
  logic [ADDR_W-1:0] cur_addr;
  logic [ADDR_W-1:0] eff_addr;
  logic [DATA_W-1:0] rdata;
  logic              rd_valid_q;
  logic [ADDR_W-1:0] end_addr [NUM_EOB];
  logic [NUM_EOB-1:0] flag_n;

  assign active = !rst && !start_i;
  assign adv    = active && !cnt_en_n_i;

  always_comb begin
    if (!active || !sel_i) acc = ACC_IDLE;
    else if (wr_n_i)       acc = ACC_READ;
    else                   acc = ACC_WRITE;
  end

  seqport_counter #(.ADDR_W(ADDR_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (start_i),
    .load_val (start_ptr_i),
    .adv      (adv),
    .cur_addr (cur_addr),
    .eff_addr (eff_addr)
  );

  seqport_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk   (clk),
    .we    (acc == ACC_WRITE),
    .re    (acc == ACC_READ),
    .addr  (eff_addr),
    .wdata (data_i),
    .rdata (rdata)
  );

  assign end_addr[0] = end1_i;
  assign end_addr[1] = end2_i;

  for (genvar g = 0; g < NUM_EOB; g++) begin : g_eob
    seqport_eob_flag #(.ADDR_W(ADDR_W)) u_flag (
      .clk      (clk),
      .rst      (rst),
      .clr      (start_i),
      .adv      (adv),
      .eff_addr (eff_addr),
      .end_addr (end_addr[g]),
      .flag_n   (flag_n[g])
    );
  end

  assign eob1_n_o = flag_n[0];
  assign eob2_n_o = flag_n[1];

  // Read data stays valid until the next edge that is not a selected read.
  always_ff @(posedge clk) begin
    if (!active) rd_valid_q <= 1'b0;
    else         rd_valid_q <= (acc == ACC_READ);
  end

  assign data_oe_o = rd_valid_q && !oe_n_i;
  assign data_o    = data_oe_o ? rdata : '0;
endmodule

// File: rtl/seqport_checker.sv
`timescale 1ns/1ps
module seqport_checker #(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic [ADDR_W-1:0] start_ptr_i,
  input logic              sel_i,
  input logic              cnt_en_n_i,
  input logic              oe_n_i,
  input logic              data_oe_o,
  input logic              eob1_n_o,
  input logic              eob2_n_o,
  input logic [ADDR_W-1:0] cur_addr
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (eob1_n_o && eob2_n_o && !data_oe_o && cur_addr == $past(start_ptr_i)));

  assert_start_load_R2: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (eob1_n_o && eob2_n_o && !data_oe_o && cur_addr == $past(start_ptr_i)));

  assert_step_first_R3: assert property (@(posedge clk) disable iff (rst)
    (!start_i && !cnt_en_n_i) |=> (cur_addr == ADDR_W'($past(cur_addr) + 1'b1)));

  assert_no_step_R4: assert property (@(posedge clk) disable iff (rst)
    (!start_i && cnt_en_n_i) |=> $stable(cur_addr));

  assert_oe_gate_R5: assert property (@(posedge clk) disable iff (rst)
    data_oe_o |-> !oe_n_i);

  assert_deselect_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    !sel_i |=> !data_oe_o);

  assert_flag1_fall_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(eob1_n_o) |-> ($past(cnt_en_n_i) == 1'b0));

  assert_flag2_fall_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(eob2_n_o) |-> ($past(cnt_en_n_i) == 1'b0));

  assert_flag_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!start_i && cnt_en_n_i) |=> ($stable(eob1_n_o) && $stable(eob2_n_o)));

  assert_wrap_R10: assert property (@(posedge clk) disable iff (rst)
    (!start_i && !cnt_en_n_i && cur_addr == '1) |=> (cur_addr == '0));
endmodule

bind seqport_buffer seqport_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .start_i     (start_i),
  .start_ptr_i (start_ptr_i),
  .sel_i       (sel_i),
  .cnt_en_n_i  (cnt_en_n_i),
  .oe_n_i      (oe_n_i),
  .data_oe_o   (data_oe_o),
  .eob1_n_o    (eob1_n_o),
  .eob2_n_o    (eob2_n_o),
  .cur_addr    (cur_addr)
);

// File: tb/sim_seqport_buffer.sv
`timescale 1ns/1ps
module sim_seqport_buffer;
  localparam int AW    = 11;
  localparam int DW    = 16;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0;
  logic [AW-1:0] start_ptr_i = '0;
  logic [AW-1:0] end1_i = '0;
  logic [AW-1:0] end2_i = '0;
  logic          sel_i = 1'b0;
  logic          cnt_en_n_i = 1'b1;
  logic          wr_n_i = 1'b1;
  logic          oe_n_i = 1'b1;
  logic [DW-1:0] data_i = '0;
  logic [DW-1:0] data_o;
  logic          data_oe_o;
  logic          eob1_n_o;
  logic          eob2_n_o;

  int checks = 0;
  int errors = 0;
  string scen = "init";

  always #4 clk = ~clk;

  seqport_buffer #(.ADDR_W(AW), .DATA_W(DW)) u0 (.*);

  // Behavioural reference model
  logic [DW-1:0] m_mem [DEPTH];
  int            m_addr = 0;
  logic          m_f1 = 1'b1, m_f2 = 1'b1, m_valid = 1'b0;
  logic [DW-1:0] m_rd = '0;

  always @(posedge clk) begin
    if (rst || start_i) begin
      m_addr = int'(start_ptr_i); m_f1 = 1'b1; m_f2 = 1'b1; m_valid = 1'b0;
    end else begin
      if (!cnt_en_n_i) begin
        m_addr = (m_addr + 1) % DEPTH;
        if (m_addr == int'(end1_i)) m_f1 = 1'b0;
        if (m_addr == int'(end2_i)) m_f2 = 1'b0;
      end
      m_valid = 1'b0;
      if (sel_i) begin
        if (wr_n_i) begin m_rd = m_mem[m_addr]; m_valid = 1'b1; end
        else m_mem[m_addr] = data_i;
      end
    end
  end

  function automatic logic [DW-1:0] pat(int i);
    return DW'(i * 40503 + 7);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s (%s): actual=%h expected=%h", tag, scen, act, exp);
    end
  endtask

  task automatic model_cmp();
    logic          e_oe;
    logic [DW-1:0] e_d;
    e_oe = m_valid && !oe_n_i;
    e_d  = e_oe ? m_rd : '0;
    chk("R5 R6 drive enable", 32'(data_oe_o), 32'(e_oe));
    chk("R3 R4 R9 read data", 32'(data_o), 32'(e_d));
    chk("R7 R8 marker 1", 32'(eob1_n_o), 32'(m_f1));
    chk("R7 R8 marker 2", 32'(eob2_n_o), 32'(m_f2));
  endtask

  // Drive one cycle at the falling edge, compare at the next falling edge.
  task automatic step(logic s, logic cen_n, logic wn, logic oen, logic [DW-1:0] d, logic st);
    sel_i = s; cnt_en_n_i = cen_n; wr_n_i = wn; oe_n_i = oen; data_i = d; start_i = st;
    @(posedge clk);
    @(negedge clk);
    model_cmp();
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R1..all watchdog: actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    // R1: reset state, pointer parked at the top so the fill starts at 0
    scen = "reset";
    start_ptr_i = AW'(DEPTH - 1); end1_i = AW'(20); end2_i = AW'(30);
    @(negedge clk); @(negedge clk);
    model_cmp();
    chk("R1 marker1 after reset", 32'(eob1_n_o), 32'd1);
    chk("R1 drive after reset", 32'(data_oe_o), 32'd0);
    rst = 1'b0;

    // R9 R10: fill the whole array by advancing writes (wraps to 0 first)
    scen = "fill";
    for (int i = 0; i < DEPTH; i++) step(1, 0, 0, 1, pat(i), 0);
    chk("R7 both markers low after fill", 32'({eob1_n_o, eob2_n_o}), 32'd0);

    // R2: start strobe
    scen = "start";
    start_ptr_i = AW'(5);
    step(1, 0, 1, 0, '0, 1);
    chk("R2 markers high after start", 32'({eob1_n_o, eob2_n_o}), 32'b11);
    chk("R2 no drive on start", 32'(data_oe_o), 32'd0);

    // R4: non-stepping read at start address
    scen = "hold read";
    step(1, 1, 1, 0, '0, 0);
    chk("R4 word at start address", 32'(data_o), 32'(pat(5)));

    // R3 R7: advancing reads up to end1 then end2
    scen = "advance read";
    for (int i = 0; i < 15; i++) step(1, 0, 1, 0, '0, 0);
    chk("R3 word 20", 32'(data_o), 32'(pat(20)));
    chk("R7 marker1 low only", 32'({eob1_n_o, eob2_n_o}), 32'b01);
    for (int i = 0; i < 10; i++) step(1, 0, 1, 0, '0, 0);
    chk("R7 marker2 low too", 32'({eob1_n_o, eob2_n_o}), 32'b00);

    // R8: sitting on end address without stepping does not drop marker
    scen = "hold on end";
    start_ptr_i = AW'(40); end1_i = AW'(40); end2_i = AW'(41);
    step(0, 1, 1, 1, '0, 1);
    for (int i = 0; i < 3; i++) step(1, 1, 1, 0, '0, 0);
    chk("R8 marker1 held high", 32'(eob1_n_o), 32'd1);

    // R6: deselected advance, then deselected hold
    scen = "deselect";
    for (int i = 0; i < 3; i++) step(0, 0, 1, 0, '0, 0);
    chk("R6 no drive deselected", 32'(data_oe_o), 32'd0);
    chk("R7 marker2 dropped while deselected", 32'(eob2_n_o), 32'd0);
    step(0, 1, 0, 0, 16'hDEAD, 0);
    step(1, 1, 1, 0, '0, 0);
    chk("R6 pointer moved while deselected", 32'(data_o), 32'(pat(43)));

    // R5: output enable high during read
    scen = "oe high";
    step(1, 1, 1, 1, '0, 0);
    chk("R5 no drive with oe high", 32'(data_oe_o), 32'd0);

    // R9: non-stepping write then readback
    scen = "write back";
    step(1, 1, 0, 1, 16'hBEEF, 0);
    step(1, 1, 1, 0, '0, 0);
    chk("R9 readback", 32'(data_o), 32'hBEEF);

    // R10: wrap on read
    scen = "wrap";
    start_ptr_i = AW'(DEPTH - 1);
    step(0, 1, 1, 1, '0, 1);
    step(1, 0, 1, 0, '0, 0);
    chk("R10 wrapped to word 0", 32'(data_o), 32'(pat(0)));

    // Mixed traffic compared against the model every cycle
    scen = "mixed";
    for (int i = 0; i < 600; i++) begin
      if (i % 97 == 0) begin
        start_ptr_i = AW'($urandom_range(0, DEPTH - 1));
        end1_i = start_ptr_i + AW'($urandom_range(1, 20));
        end2_i = start_ptr_i + AW'($urandom_range(1, 20));
      end
      step(1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 2) != 0), 1'($urandom_range(0, 4) == 0),
           DW'($urandom), 1'($urandom_range(0, 40) == 0));
    end

    summary();
    $finish;
  end
endmodule